// File: doc/BRIEF.md
# Pointer-Register Address Generation Unit

This block turns a memory-access request from the instruction decoder into a data-space address. Three 16-bit pointers (called X, Y and Z here) are each held as a pair of 8-bit working registers. The decoder supplies the value of the selected pair, the addressing mode, a 6-bit displacement and a 16-bit direct address. One cycle later the unit returns the effective address, the region the address falls in, and, for the auto-modifying modes, the new pointer value together with a write enable for the register file's 16-bit pair port.

The data space is one linear map. The lowest 32 bytes alias the working registers. The next 64 bytes are I/O locations. The 128 bytes after that are SRAM. Any address above the SRAM is flagged and no access is made. For the constant-table load, the Z pointer is instead split into a program-memory word address and a byte select. The fetched byte is destined for register 0; that steering is done by the register file. The register file, the memories and the instruction decode lie outside this block.

Top module: `agu_ptr_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is zero.
- R2: Each output is registered. The result of a request sampled at a clock edge appears after that edge, and `out_valid` repeats `req_valid`. When `req_valid` was low, every output is zero.
- R3: Pointer select codes are X=0, Y=1 and Z=2; code 3 is illegal. Mode codes are: plain=0, post-increment=1, pre-decrement=2, displacement=3, direct=4, constant load=5. Codes 6 and 7 are illegal.
- R4: Plain mode uses the pointer value unchanged as `eff_addr`, with `ptr_wr_en` low.
- R5: Post-increment mode accesses at the pointer value. It writes back the pointer plus one modulo 2^16, so FFFF becomes 0000. `ptr_wr_sel` equals the selected pointer.
- R6: Pre-decrement mode accesses at, and writes back, the pointer minus one modulo 2^16, so 0000 becomes FFFF.
- R7: Displacement mode gives the pointer plus the unsigned 6-bit `req_disp`, modulo 2^16, with no write-back. It is legal only for Y and Z.
- R8: Direct mode uses `req_direct` and ignores `ptr_value` and `req_ptr`. It makes no write-back.
- R9: For a data access, addresses 0000–001F give `region`=0 (registers), 0020–005F give 1 (I/O), and 0060–00DF give 2 (SRAM), each with `data_en` high.
- R10: A data address above 00DF sets `out_of_range`, keeps `data_en` low and gives `region`=3. `eff_addr` and any pointer write-back are still reported.
- R11: Constant load is legal only with Z. It raises `pm_en`, sets `pm_word_addr` to Z bits 15..1 and `pm_byte_hi` to Z bit 0, and gives `region`=3. There is no data access, no write-back, and `eff_addr` is 0.
- R12: An illegal combination raises `illegal` with `region`=3. All enables, addresses and write data are zero.
- R13: When `ptr_wr_en` is low, `ptr_wr_sel` and `ptr_wr_data` are zero. When `pm_en` is low, `pm_word_addr` and `pm_byte_hi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ptr | input | 2 | Pointer select (X=0, Y=1, Z=2) |
| req_mode | input | 3 | Addressing mode code |
| req_disp | input | 6 | Unsigned displacement |
| req_direct | input | 16 | Full address for direct mode |
| ptr_value | input | 16 | Current value of the selected pointer pair |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 16 | Effective data address |
| region | output | 2 | 0 registers, 1 I/O, 2 SRAM, 3 none |
| data_en | output | 1 | Data access to be performed |
| out_of_range | output | 1 | Data address beyond SRAM |
| illegal | output | 1 | Unsupported pointer/mode combination |
| ptr_wr_en | output | 1 | Write the updated pointer back |
| ptr_wr_sel | output | 2 | Pointer pair being written |
| ptr_wr_data | output | 16 | Updated pointer (both bytes) |
| pm_en | output | 1 | Program-memory constant fetch |
| pm_word_addr | output | 15 | Program-memory word address |
| pm_byte_hi | output | 1 | 1 selects the high byte of the word |

## Verification
Seeded random requests are biased so that most pointer values land below 0100. This makes the register, I/O, SRAM and out-of-range regions all occur often, while full 16-bit values still test the arithmetic. Directed cases are aimed at specific faults. The wrap values 0000 and FFFF expose a wrong carry or borrow width. Addresses 001F/0020, 005F/0060 and 00DF/00E0 expose a boundary that is off by one. Odd and even Z values in a constant load show whether the byte select and the word shift are swapped. Displacement with X, constant load with Y, pointer code 3 and mode codes 6 and 7 show whether illegal requests are suppressed.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    PTR_X   = 2'd0,
    PTR_Y   = 2'd1,
    PTR_Z   = 2'd2,
    PTR_BAD = 2'd3
  } ptr_sel_e;

  typedef enum logic [2:0] {
    MODE_PLAIN   = 3'd0,
    MODE_POSTINC = 3'd1,
    MODE_PREDEC  = 3'd2,
    MODE_DISP    = 3'd3,
    MODE_DIRECT  = 3'd4,
    MODE_CONST   = 3'd5,
    MODE_RSV6    = 3'd6,
    MODE_RSV7    = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    RGN_REGS = 2'd0,
    RGN_IO   = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

endpackage

// File: rtl/agu_ptr_arith.sv
module agu_ptr_arith
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 6
) (
  input  logic [1:0]        ptr_sel,
  input  logic [2:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] direct,
  input  logic [ADDR_W-1:0] ptr_value,
  output logic              use_data,
  output logic [ADDR_W-1:0] ea,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_data,
  output logic              pm_en,
  output logic              bad
);

  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] ptr_dec;
  logic [ADDR_W-1:0] ptr_off;
  logic              ptr_ok;
  logic              ptr_yz;

  assign ptr_inc = ptr_value + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign ptr_dec = ptr_value - {{(ADDR_W-1){1'b0}}, 1'b1};
  assign ptr_off = ptr_value + {{PAD_W{1'b0}}, disp};
  assign ptr_ok  = (ptr_sel != PTR_BAD);
  assign ptr_yz  = (ptr_sel == PTR_Y) || (ptr_sel == PTR_Z);

  always_comb begin
    use_data = 1'b0;
    ea       = '0;
    wr_en    = 1'b0;
    wr_data  = '0;
    pm_en    = 1'b0;
    bad      = 1'b0;
    unique case (agu_mode_e'(mode))
      MODE_PLAIN: begin
        bad      = !ptr_ok;
        use_data = ptr_ok;
        ea       = ptr_value;
      end
      MODE_POSTINC: begin
        bad      = !ptr_ok;
        use_data = ptr_ok;
        ea       = ptr_value;
        wr_en    = ptr_ok;
        wr_data  = ptr_inc;
      end
      MODE_PREDEC: begin
        bad      = !ptr_ok;
        use_data = ptr_ok;
        ea       = ptr_dec;
        wr_en    = ptr_ok;
        wr_data  = ptr_dec;
      end
      MODE_DISP: begin
        bad      = !ptr_yz;
        use_data = ptr_yz;
        ea       = ptr_off;
      end
      MODE_DIRECT: begin
        use_data = 1'b1;
        ea       = direct;
      end
      MODE_CONST: begin
        bad   = (ptr_sel != PTR_Z);
        pm_en = (ptr_sel == PTR_Z);
      end
      default: bad = 1'b1;
    endcase
    if (bad) begin
      use_data = 1'b0;
      ea       = '0;
      wr_en    = 1'b0;
      wr_data  = '0;
      pm_en    = 1'b0;
    end
  end

endmodule

// File: rtl/agu_region_decode.sv
module agu_region_decode
  import agu_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REGS_TOP = 16'h001F,
  parameter logic [15:0] IO_TOP   = 16'h005F,
  parameter logic [15:0] SRAM_TOP = 16'h00DF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        rgn,
  output logic              in_range
);

  localparam int NUM_RGN = 3;
  localparam logic [ADDR_W-1:0] TOPS [NUM_RGN] = '{
    ADDR_W'(REGS_TOP), ADDR_W'(IO_TOP), ADDR_W'(SRAM_TOP)
  };

  logic [NUM_RGN-1:0] below;

  genvar g;
  generate
    for (g = 0; g < NUM_RGN; g++) begin : g_cmp
      assign below[g] = (addr <= TOPS[g]);
    end
  endgenerate

  always_comb begin
    rgn      = RGN_NONE;
    in_range = 1'b0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (below[i]) begin
        rgn      = 2'(i);
        in_range = 1'b1;
      end
    end
  end

endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PM_W   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_in,
  input  logic [ADDR_W-1:0] ea_in,
  input  logic [1:0]        rgn_in,
  input  logic              de_in,
  input  logic              oor_in,
  input  logic              bad_in,
  input  logic              we_in,
  input  logic [1:0]        ws_in,
  input  logic [ADDR_W-1:0] wd_in,
  input  logic              pm_in,
  input  logic [PM_W-1:0]   pw_in,
  input  logic              ph_in,
  output logic              v_q,
  output logic [ADDR_W-1:0] ea_q,
  output logic [1:0]        rgn_q,
  output logic              de_q,
  output logic              oor_q,
  output logic              bad_q,
  output logic              we_q,
  output logic [1:0]        ws_q,
  output logic [ADDR_W-1:0] wd_q,
  output logic              pm_q,
  output logic [PM_W-1:0]   pw_q,
  output logic              ph_q
);

  always_ff @(posedge clk) begin
    if (rst || !v_in) begin
      v_q   <= 1'b0;
      ea_q  <= '0;
      rgn_q <= '0;
      de_q  <= 1'b0;
      oor_q <= 1'b0;
      bad_q <= 1'b0;
      we_q  <= 1'b0;
      ws_q  <= '0;
      wd_q  <= '0;
      pm_q  <= 1'b0;
      pw_q  <= '0;
      ph_q  <= 1'b0;
    end else begin
      v_q   <= 1'b1;
      ea_q  <= ea_in;
      rgn_q <= rgn_in;
      de_q  <= de_in;
      oor_q <= oor_in;
      bad_q <= bad_in;
      we_q  <= we_in;
      ws_q  <= ws_in;
      wd_q  <= wd_in;
      pm_q  <= pm_in;
      pw_q  <= pw_in;
      ph_q  <= ph_in;
    end
  end

  // R2: the valid output repeats the request one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    v_in |=> v_q);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> (!v_q && !de_q && !we_q && !pm_q && !bad_q));
  // R10: no access beyond the SRAM
  a_r10_oor_no_access: assert property (@(posedge clk) disable iff (rst)
    oor_q |-> (!de_q && rgn_q == RGN_NONE));
  // R11: a constant fetch makes neither a data access nor a write-back
  a_r11_pm_exclusive: assert property (@(posedge clk) disable iff (rst)
    pm_q |-> (!de_q && !we_q && !oor_q));
  // R12: illegal requests do nothing
  a_r12_illegal_inert: assert property (@(posedge clk) disable iff (rst)
    bad_q |-> (!de_q && !we_q && !pm_q && ea_q == '0));

endmodule

// File: rtl/agu_ptr_unit.sv
module agu_ptr_unit
  import agu_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DISP_W   = 6,
  parameter logic [15:0] REGS_TOP = 16'h001F,
  parameter logic [15:0] IO_TOP   = 16'h005F,
  parameter logic [15:0] SRAM_TOP = 16'h00DF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_ptr,
  input  logic [2:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [ADDR_W-1:0] req_direct,
  input  logic [ADDR_W-1:0] ptr_value,
  output logic              out_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [1:0]        region,
  output logic              data_en,
  output logic              out_of_range,
  output logic              illegal,
  output logic              ptr_wr_en,
  output logic [1:0]        ptr_wr_sel,
  output logic [ADDR_W-1:0] ptr_wr_data,
  output logic              pm_en,
  output logic [ADDR_W-2:0] pm_word_addr,
  output logic              pm_byte_hi
);

  localparam int PM_W = ADDR_W - 1;

  logic              use_data;
  logic [ADDR_W-1:0] ea_c;
  logic              we_c;
  logic [ADDR_W-1:0] wd_c;
  logic              pm_c;
  logic              bad_c;
  logic [1:0]        dec_rgn;
  logic              dec_in;
  logic              de_c;
  logic              oor_c;
  logic [1:0]        rgn_c;
  logic [1:0]        ws_c;
  logic [PM_W-1:0]   pw_c;
  logic              ph_c;

  agu_ptr_arith #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_arith (
    .ptr_sel   (req_ptr),
    .mode      (req_mode),
    .disp      (req_disp),
    .direct    (req_direct),
    .ptr_value (ptr_value),
    .use_data  (use_data),
    .ea        (ea_c),
    .wr_en     (we_c),
    .wr_data   (wd_c),
    .pm_en     (pm_c),
    .bad       (bad_c)
  );

  agu_region_decode #(
    .ADDR_W   (ADDR_W),
    .REGS_TOP (REGS_TOP),
    .IO_TOP   (IO_TOP),
    .SRAM_TOP (SRAM_TOP)
  ) u_decode (
    .addr     (ea_c),
    .rgn      (dec_rgn),
    .in_range (dec_in)
  );

  assign de_c  = use_data && dec_in;
  assign oor_c = use_data && !dec_in;
  assign rgn_c = de_c ? dec_rgn : RGN_NONE;
  assign ws_c  = we_c ? req_ptr : 2'd0;
  assign pw_c  = pm_c ? ptr_value[ADDR_W-1:1] : '0;
  assign ph_c  = pm_c && ptr_value[0];

  agu_out_reg #(
    .ADDR_W (ADDR_W),
    .PM_W   (PM_W)
  ) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .v_in   (req_valid),
    .ea_in  (ea_c),
    .rgn_in (rgn_c),
    .de_in  (de_c),
    .oor_in (oor_c),
    .bad_in (bad_c),
    .we_in  (we_c),
    .ws_in  (ws_c),
    .wd_in  (wd_c),
    .pm_in  (pm_c),
    .pw_in  (pw_c),
    .ph_in  (ph_c),
    .v_q    (out_valid),
    .ea_q   (eff_addr),
    .rgn_q  (region),
    .de_q   (data_en),
    .oor_q  (out_of_range),
    .bad_q  (illegal),
    .we_q   (ptr_wr_en),
    .ws_q   (ptr_wr_sel),
    .wd_q   (ptr_wr_data),
    .pm_q   (pm_en),
    .pw_q   (pm_word_addr),
    .ph_q   (pm_byte_hi)
  );

  // R5: post-increment writes back the sampled pointer plus one
  a_r5_postinc_wb: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == MODE_POSTINC && req_ptr != PTR_BAD) |=>
      (ptr_wr_en && ptr_wr_data == $past(ptr_value) + 1'b1 &&
       eff_addr == $past(ptr_value)));
  // R7: displacement never modifies the pointer
  a_r7_disp_no_wb: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == MODE_DISP) |=> !ptr_wr_en);
  // R8: direct mode takes the full address from the request
  a_r8_direct_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == MODE_DIRECT) |=>
      (eff_addr == $past(req_direct) && !ptr_wr_en && !illegal));
  // R9: a performed access always names a real region
  a_r9_region_named: assert property (@(posedge clk) disable iff (rst)
    data_en |-> (region != RGN_NONE && eff_addr <= SRAM_TOP));

endmodule

// File: tb/test_agu_ptr_unit.sv
`timescale 1ns/1ps
module test_agu_ptr_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_ptr = '0;
  logic [2:0]  req_mode = '0;
  logic [5:0]  req_disp = '0;
  logic [15:0] req_direct = '0;
  logic [15:0] ptr_value = '0;
  logic        out_valid;
  logic [15:0] eff_addr;
  logic [1:0]  region;
  logic        data_en, out_of_range, illegal, ptr_wr_en, pm_en, pm_byte_hi;
  logic [1:0]  ptr_wr_sel;
  logic [15:0] ptr_wr_data;
  logic [14:0] pm_word_addr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  agu_ptr_unit i_agu_ptr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ptr(req_ptr),
    .req_mode(req_mode), .req_disp(req_disp), .req_direct(req_direct),
    .ptr_value(ptr_value), .out_valid(out_valid), .eff_addr(eff_addr),
    .region(region), .data_en(data_en), .out_of_range(out_of_range),
    .illegal(illegal), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
    .ptr_wr_data(ptr_wr_data), .pm_en(pm_en), .pm_word_addr(pm_word_addr),
    .pm_byte_hi(pm_byte_hi)
  );

  typedef struct packed {
    logic        v;
    logic [15:0] ea;
    logic [1:0]  rg;
    logic        de, oor, ill, we;
    logic [1:0]  ws;
    logic [15:0] wd;
    logic        pe;
    logic [14:0] pw;
    logic        ph;
  } res_t;

  function automatic res_t model(logic v, logic [1:0] p, logic [2:0] m,
                                 logic [5:0] d, logic [15:0] dir, logic [15:0] pv);
    res_t e;
    bit ok;
    bit data;
    bit wr;
    logic [15:0] a;
    logic [15:0] nw;
    e = '0;
    if (!v) return e;
    e.v = 1'b1;
    ok = 1'b1; data = 1'b1; wr = 1'b0; a = 16'h0; nw = 16'h0;
    case (m)
      3'd0: begin ok = (p != 2'd3); a = pv; end
      3'd1: begin ok = (p != 2'd3); a = pv; wr = 1'b1; nw = 16'(pv + 17'd1); end
      3'd2: begin ok = (p != 2'd3); a = 16'(pv - 16'd1); wr = 1'b1; nw = a; end
      3'd3: begin ok = (p == 2'd1 || p == 2'd2); a = 16'(pv + {10'd0, d}); end
      3'd4: begin a = dir; end
      3'd5: begin ok = (p == 2'd2); data = 1'b0; end
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      e.ill = 1'b1;
      e.rg  = 2'd3;
      return e;
    end
    if (wr) begin e.we = 1'b1; e.ws = p; e.wd = nw; end
    if (data) begin
      e.ea = a;
      if (a < 16'h0020)      begin e.rg = 2'd0; e.de = 1'b1; end
      else if (a < 16'h0060) begin e.rg = 2'd1; e.de = 1'b1; end
      else if (a < 16'h00E0) begin e.rg = 2'd2; e.de = 1'b1; end
      else                   begin e.rg = 2'd3; e.oor = 1'b1; end
    end else begin
      e.rg = 2'd3;
      e.pe = 1'b1;
      e.pw = pv[15:1];
      e.ph = pv[0];
    end
    return e;
  endfunction

  function automatic string tag_of(logic v, logic [1:0] p, logic [2:0] m, res_t e);
    if (!v) return "R2";
    if (e.ill) return "R12";
    if (e.oor) return "R10";
    case (m)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R11";
      default: return "R3";
    endcase
  endfunction

  function automatic res_t actual();
    res_t a;
    a = '{out_valid, eff_addr, region, data_en, out_of_range, illegal,
          ptr_wr_en, ptr_wr_sel, ptr_wr_data, pm_en, pm_word_addr, pm_byte_hi};
    return a;
  endfunction

  task automatic check(string tag, res_t exp);
    res_t got;
    got = actual();
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, result registered at the next rising edge,
  // compared at the falling edge after it
  task automatic run(logic v, logic [1:0] p, logic [2:0] m, logic [5:0] d,
                     logic [15:0] dir, logic [15:0] pv, string tag = "");
    res_t e;
    req_valid = v; req_ptr = p; req_mode = m; req_disp = d;
    req_direct = dir; ptr_value = pv;
    e = model(v, p, m, d, dir, pv);
    @(negedge clk);
    check(tag == "" ? tag_of(v, p, m, e) : tag, e);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", '0);
    req_valid = 1'b1; req_mode = 3'd1; ptr_value = 16'h0040;
    @(negedge clk);
    check("R1", '0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check("R1", '0);

    // R4, R13: plain mode, no write-back, write fields zero
    run(1, 2'd0, 3'd0, 6'd5, 16'h1234, 16'h0010, "R4");
    // R5: post-increment wrap and ordinary
    run(1, 2'd1, 3'd1, 6'd0, 16'h0, 16'hFFFF, "R5");
    run(1, 2'd0, 3'd1, 6'd0, 16'h0, 16'h0065, "R5");
    // R6: pre-decrement wrap and ordinary
    run(1, 2'd2, 3'd2, 6'd0, 16'h0, 16'h0000, "R6");
    run(1, 2'd1, 3'd2, 6'd0, 16'h0, 16'h0060, "R6");
    // R7: displacement on Y and Z, illegal on X
    run(1, 2'd1, 3'd3, 6'd63, 16'h0, 16'h00A0, "R7");
    run(1, 2'd2, 3'd3, 6'd1, 16'h0, 16'hFFFF, "R7");
    run(1, 2'd0, 3'd3, 6'd4, 16'h0, 16'h0020, "R7");
    // R8: direct ignores pointer inputs
    run(1, 2'd3, 3'd4, 6'd9, 16'h0055, 16'hBEEF, "R8");
    // R9, R10: region boundaries
    run(1, 2'd0, 3'd0, 6'd0, 16'h0, 16'h001F, "R9");
    run(1, 2'd0, 3'd0, 6'd0, 16'h0, 16'h0020, "R9");
    run(1, 2'd0, 3'd0, 6'd0, 16'h0, 16'h005F, "R9");
    run(1, 2'd0, 3'd0, 6'd0, 16'h0, 16'h0060, "R9");
    run(1, 2'd0, 3'd0, 6'd0, 16'h0, 16'h00DF, "R9");
    run(1, 2'd0, 3'd0, 6'd0, 16'h0, 16'h00E0, "R10");
    run(1, 2'd2, 3'd1, 6'd0, 16'h0, 16'h00E0, "R10");
    // R11: constant load odd/even, and on Y
    run(1, 2'd2, 3'd5, 6'd0, 16'h0, 16'h1235, "R11");
    run(1, 2'd2, 3'd5, 6'd0, 16'h0, 16'hFFFE, "R11");
    run(1, 2'd1, 3'd5, 6'd0, 16'h0, 16'h1235, "R11");
    // R3, R12: bad codes
    run(1, 2'd3, 3'd0, 6'd0, 16'h0, 16'h0010, "R12");
    run(1, 2'd1, 3'd6, 6'd0, 16'h0, 16'h0010, "R3");
    run(1, 2'd1, 3'd7, 6'd0, 16'h0, 16'h0010, "R3");
    // R2: idle
    run(0, 2'd1, 3'd1, 6'd0, 16'h0, 16'h0010, "R2");

    for (int i = 0; i < 1500; i++) begin
      logic [15:0] pv;
      logic [15:0] dv;
      pv = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 256);
      dv = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 256);
      run(($urandom % 8) != 0, 2'($urandom), 3'($urandom), 6'($urandom), dv, pv);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule